// File: doc/BRIEF.md
# Command and Parameter Protocol Controller

This block sits on the instrument side of a register-based link and interprets 16-bit command words written by a bus controller. A command word carries an opaque application code in its upper byte, a 4-bit default command code in bits 7:4, and two flags in bits 1:0. One flag says whether a parameter follows. The other says whether that parameter is one data word or two.

When a parameter is announced, the block waits for it on the low data-input register. A wide parameter also needs a following write to the high data-input register. The command executes only after its last parameter word has arrived. Each execution is a single-cycle pulse that carries the code, the application byte and the assembled parameter. Three of the default commands also load settings: the input buffer size, the output buffer size and the sample-rate value.

The block keeps a 16-bit status word for the controller to read. The low five bits show the protocol state: parameter pending, which parameter width is awaited, input data awaited, and output data ready. The upper eleven bits are supplied from outside.

Top module: `cmd_proto_ctrl`

## Requirements
- R1: After reset, status bits 4:0 are 0, `exec_valid` and `err_pulse` are 0, and `in_size`, `out_size` and `fs_set` are 0.
- R2: A command write with a known code and bit 0 clear gives `exec_valid` high for exactly the next cycle. In that cycle `exec_code` equals word bits 7:4, `exec_app` equals word bits 15:8, and `exec_param` is 0. The known codes are 0000, 0001, 0010, 0011, 1100, 1101, 1110 and 1111.
- R3: A command write whose code is 0100 through 1011 gives `err_pulse` high for the next cycle, with no execute pulse. It also drops any parameter that was pending.
- R4: A known command with bit 0 set and bit 1 clear sets status bit 3 and status bit 0 and does not execute. The next low data write executes it with the data word zero-extended as parameter. Status bits 3, 1 and 0 clear in the same cycle as that execute pulse.
- R5: A known command with bits 1 and 0 both set sets status bits 3 and 1. It then needs a low write followed by a high write. It executes on the high write with parameter {high word, low word}, and status bit 1 stays set until then.
- R6: While the low word is awaited, a high data write is ignored. While the high word is awaited, a low data write is ignored.
- R7: A command write while a parameter is pending abandons the pending command, and the new word is decoded on its own. A command write has priority over a data write in the same cycle.
- R8: On execution, code 0010 loads its parameter into `in_size`, code 0011 loads it into `out_size`, and code 1110 loads it into `fs_set`. These outputs change at no other time.
- R9: Status bit 2 is set after code 0010 executes with a nonzero parameter N. It clears after N low data writes made while no parameter is pending, or when code 1101 executes. High data writes do not count toward N.
- R10: Status bit 4 sets one cycle after `resp_ready`. It clears one cycle after `dout_rd_done`, or when code 1100 executes. If a set and a clear come in the same cycle, the set wins.
- R11: Status bits 15:5 always equal the `app_status` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write event |
| cmd_word | input | 16 | Command word |
| din_lo_wr | input | 1 | Low data-input register write event |
| din_hi_wr | input | 1 | High data-input register write event |
| din_word | input | 16 | Data word for either data-input write |
| resp_ready | input | 1 | Instrument has output data for the controller |
| dout_rd_done | input | 1 | Controller has read the last output word |
| app_status | input | 11 | Application-owned status bits 15:5 |
| status | output | 16 | Instrument status word |
| exec_valid | output | 1 | One-cycle execute pulse |
| exec_code | output | 4 | Default command code of the executed command |
| exec_app | output | 8 | Application code of the executed command |
| exec_param | output | 32 | Assembled parameter (0 if none) |
| err_pulse | output | 1 | One-cycle pulse for an unknown default code |
| in_size | output | 32 | Input buffer size setting |
| out_size | output | 32 | Output buffer size setting |
| fs_set | output | 32 | Sample-rate setting |

## Verification
The decoder is swept over all sixteen default codes, each combined with all four settings of the parameter flags. This separates known codes from unknown ones, and no-parameter commands from narrow and wide parameter commands, with the expected parameter built from the words sent. Directed sequences then use misordered data writes, a new command issued in the middle of a parameter, and same-cycle command and data writes. These show whether pending state is dropped or kept in the right cases. A size-then-data sequence shows whether the input-data wait counts only the low data writes made outside a parameter. Set-and-clear pairs on the ready flag show which event wins.

// File: rtl/cmd_proto_pkg.sv
// Shared constants for the command/parameter protocol controller.
// Assumes 16-bit command words with the code field in bits 7:4.
package cmd_proto_pkg;

    typedef enum logic [3:0] {
        DC_GET_STATUS  = 4'b0000,
        DC_APP         = 4'b0001,
        DC_SET_INSIZE  = 4'b0010,
        DC_SET_OUTSIZE = 4'b0011,
        DC_STOP_OUT    = 4'b1100,
        DC_STOP_IN     = 4'b1101,
        DC_SET_FS      = 4'b1110,
        DC_USER1       = 4'b1111
    } dflt_cmd_e;

    localparam int CODE_LSB  = 4;
    localparam int CODE_W    = 4;
    localparam int APP_LSB   = 8;
    localparam int FLAG_PARM = 0;
    localparam int FLAG_WIDE = 1;
    localparam int ST_FREE_LSB = 5;

    // True for the codes in the default table
    function automatic logic code_known(input logic [CODE_W-1:0] c);
        return (c <= 4'd3) || (c >= 4'd12);
    endfunction

endpackage

// File: rtl/cmd_field_decode.sv
// Splits a command word into its fields and classifies the default code.
// Purely combinational; assumes the field layout in cmd_proto_pkg.
module cmd_field_decode
    import cmd_proto_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int APP_W = WORD_W - APP_LSB
) (
    input  logic [WORD_W-1:0] word,
    output logic [APP_W-1:0]  app,
    output logic [CODE_W-1:0] code,
    output logic              known,
    output logic              has_param,
    output logic              wide
);

    // Field extraction and code classification
    always_comb begin
        app       = word[WORD_W-1:APP_LSB];
        code      = word[CODE_LSB +: CODE_W];
        known     = code_known(word[CODE_LSB +: CODE_W]);
        has_param = word[FLAG_PARM];
        wide      = word[FLAG_WIDE];
    end

endmodule

// File: rtl/cmd_param_fsm.sv
// Collects the optional parameter of a command and produces the fire event
// (combinational, in the cycle of the completing write). A new command write
// always overrides pending state and any same-cycle data write.
module cmd_param_fsm
    import cmd_proto_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int APP_W   = WORD_W - APP_LSB,
    localparam int PARAM_W = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [APP_W-1:0]   dec_app,
    input  logic [CODE_W-1:0]  dec_code,
    input  logic               dec_known,
    input  logic               dec_has_param,
    input  logic               dec_wide,
    input  logic               din_lo_wr,
    input  logic               din_hi_wr,
    input  logic [WORD_W-1:0]  din_word,
    output logic               fire,
    output logic [CODE_W-1:0]  fire_code,
    output logic [APP_W-1:0]   fire_app,
    output logic [PARAM_W-1:0] fire_param,
    output logic               bad_code,
    output logic               pend,
    output logic               pend_wide,
    output logic               free_lo_wr
);

    typedef enum logic [1:0] {PS_IDLE, PS_LO, PS_HI} pstate_e;

    pstate_e             state_q, state_d;
    logic [CODE_W-1:0]   code_q;
    logic [APP_W-1:0]    app_q;
    logic                wide_q;
    logic [WORD_W-1:0]   lo_q;
    logic                cap_cmd, cap_lo;

    // Next state, fire event and capture strobes
    always_comb begin
        state_d    = state_q;
        fire       = 1'b0;
        fire_code  = code_q;
        fire_app   = app_q;
        fire_param = '0;
        cap_cmd    = 1'b0;
        cap_lo     = 1'b0;
        bad_code   = cmd_wr && !dec_known;
        free_lo_wr = 1'b0;
        if (cmd_wr) begin
            state_d = PS_IDLE;
            if (dec_known && !dec_has_param) begin
                fire      = 1'b1;
                fire_code = dec_code;
                fire_app  = dec_app;
            end else if (dec_known) begin
                state_d = PS_LO;
                cap_cmd = 1'b1;
            end
        end else begin
            case (state_q)
                PS_LO: if (din_lo_wr) begin
                    if (wide_q) begin
                        state_d = PS_HI;
                        cap_lo  = 1'b1;
                    end else begin
                        state_d    = PS_IDLE;
                        fire       = 1'b1;
                        fire_param = {{WORD_W{1'b0}}, din_word};
                    end
                end
                PS_HI: if (din_hi_wr) begin
                    state_d    = PS_IDLE;
                    fire       = 1'b1;
                    fire_param = {din_word, lo_q};
                end
                default: free_lo_wr = din_lo_wr;
            endcase
        end
    end

    // State and held-command registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            code_q  <= '0;
            app_q   <= '0;
            wide_q  <= 1'b0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (cap_cmd) begin
                code_q <= dec_code;
                app_q  <= dec_app;
                wide_q <= dec_wide;
            end
            if (cap_lo) lo_q <= din_word;
        end
    end

    assign pend      = (state_q != PS_IDLE);
    assign pend_wide = pend && wide_q;

endmodule

// File: rtl/cmd_status_track.sv
// Holds the settings loaded by executed commands, the input-data word
// countdown and the output-data-ready flag. Assumes fire and free_lo_wr
// are never high together.
module cmd_status_track
    import cmd_proto_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int PARAM_W = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [CODE_W-1:0]  fire_code,
    input  logic [PARAM_W-1:0] fire_param,
    input  logic               free_lo_wr,
    input  logic               resp_ready,
    input  logic               dout_rd_done,
    output logic [PARAM_W-1:0] in_size,
    output logic [PARAM_W-1:0] out_size,
    output logic [PARAM_W-1:0] fs_set,
    output logic               wait_data,
    output logic               data_rdy
);

    logic [PARAM_W-1:0] remain_q;

    // Settings and input-word countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_size  <= '0;
            out_size <= '0;
            fs_set   <= '0;
            remain_q <= '0;
        end else if (fire) begin
            case (fire_code)
                DC_SET_INSIZE: begin
                    in_size  <= fire_param;
                    remain_q <= fire_param;
                end
                DC_STOP_IN:     remain_q <= '0;
                DC_SET_OUTSIZE: out_size <= fire_param;
                DC_SET_FS:      fs_set   <= fire_param;
                default: ;
            endcase
        end else if (free_lo_wr && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Output-data-ready flag; a set beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_rdy <= 1'b0;
        else if (resp_ready)
            data_rdy <= 1'b1;
        else if (dout_rd_done || (fire && fire_code == DC_STOP_OUT))
            data_rdy <= 1'b0;
    end

    assign wait_data = (remain_q != '0);

endmodule

// File: rtl/cmd_proto_ctrl.sv
// Top of the command/parameter protocol controller. Decodes command words,
// collects parameters, registers the execute and error pulses, and builds
// the status word. All event inputs are single-cycle strobes.
module cmd_proto_ctrl
    import cmd_proto_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int APP_W   = WORD_W - APP_LSB,
    localparam int PARAM_W = 2 * WORD_W,
    localparam int FREE_W  = WORD_W - ST_FREE_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [WORD_W-1:0]  cmd_word,
    input  logic               din_lo_wr,
    input  logic               din_hi_wr,
    input  logic [WORD_W-1:0]  din_word,
    input  logic               resp_ready,
    input  logic               dout_rd_done,
    input  logic [FREE_W-1:0]  app_status,
    output logic [WORD_W-1:0]  status,
    output logic               exec_valid,
    output logic [CODE_W-1:0]  exec_code,
    output logic [APP_W-1:0]   exec_app,
    output logic [PARAM_W-1:0] exec_param,
    output logic               err_pulse,
    output logic [PARAM_W-1:0] in_size,
    output logic [PARAM_W-1:0] out_size,
    output logic [PARAM_W-1:0] fs_set
);

    logic [APP_W-1:0]   d_app;
    logic [CODE_W-1:0]  d_code;
    logic               d_known, d_parm, d_wide;
    logic               fire, bad_code, pend, pend_wide, free_lo_wr;
    logic [CODE_W-1:0]  fire_code;
    logic [APP_W-1:0]   fire_app;
    logic [PARAM_W-1:0] fire_param;
    logic               wait_data, data_rdy;

    cmd_field_decode #(.WORD_W(WORD_W)) dec_i (
        .word(cmd_word), .app(d_app), .code(d_code), .known(d_known),
        .has_param(d_parm), .wide(d_wide)
    );

    cmd_param_fsm #(.WORD_W(WORD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .dec_app(d_app), .dec_code(d_code), .dec_known(d_known),
        .dec_has_param(d_parm), .dec_wide(d_wide),
        .din_lo_wr(din_lo_wr), .din_hi_wr(din_hi_wr), .din_word(din_word),
        .fire(fire), .fire_code(fire_code), .fire_app(fire_app),
        .fire_param(fire_param), .bad_code(bad_code), .pend(pend),
        .pend_wide(pend_wide), .free_lo_wr(free_lo_wr)
    );

    cmd_status_track #(.WORD_W(WORD_W)) trk_i (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_code(fire_code),
        .fire_param(fire_param), .free_lo_wr(free_lo_wr),
        .resp_ready(resp_ready), .dout_rd_done(dout_rd_done),
        .in_size(in_size), .out_size(out_size), .fs_set(fs_set),
        .wait_data(wait_data), .data_rdy(data_rdy)
    );

    // Registered execute and error outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_valid <= 1'b0;
            exec_code  <= '0;
            exec_app   <= '0;
            exec_param <= '0;
            err_pulse  <= 1'b0;
        end else begin
            exec_valid <= fire;
            err_pulse  <= bad_code;
            if (fire) begin
                exec_code  <= fire_code;
                exec_app   <= fire_app;
                exec_param <= fire_param;
            end
        end
    end

    // Status word assembly
    assign status = {app_status, data_rdy, pend, wait_data, pend_wide,
                     pend && !pend_wide};

endmodule

// File: rtl/cmd_proto_ctrl_chk.sv
// Protocol assertions for cmd_proto_ctrl, bound to every instance.
module cmd_proto_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [15:0] cmd_word,
    input logic        din_lo_wr,
    input logic        resp_ready,
    input logic        dout_rd_done,
    input logic [15:0] status,
    input logic        exec_valid,
    input logic        err_pulse,
    input logic [31:0] out_size
);

    p_exec_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_valid && err_pulse));

    p_unknown_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_word[7:4] >= 4'd4 && cmd_word[7:4] <= 4'd11)
        |=> (err_pulse && !exec_valid && !status[3]));

    p_wait_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[1:0]) && (status[3] == (status[1] || status[0])));

    p_narrow_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && din_lo_wr && !cmd_wr) |=> (exec_valid && !status[3]));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_word[0]) |=> !status[3]);

    p_setting_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |-> $stable(out_size));

    p_ready_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |=> status[4]);

    p_ready_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_rd_done && !resp_ready) |=> !status[4]);

endmodule

bind cmd_proto_ctrl cmd_proto_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .din_lo_wr(din_lo_wr), .resp_ready(resp_ready),
    .dout_rd_done(dout_rd_done), .status(status), .exec_valid(exec_valid),
    .err_pulse(err_pulse), .out_size(out_size)
);

// File: tb/cmd_proto_ctrl_tb_top.sv
// Sweep plus directed bench for cmd_proto_ctrl.
module cmd_proto_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, din_lo_wr = 1'b0, din_hi_wr = 1'b0;
    logic [15:0] cmd_word = '0, din_word = '0;
    logic        resp_ready = 1'b0, dout_rd_done = 1'b0;
    logic [10:0] app_status = 11'h2A5;
    logic [15:0] status;
    logic        exec_valid, err_pulse;
    logic [3:0]  exec_code;
    logic [7:0]  exec_app;
    logic [31:0] exec_param, in_size, out_size, fs_set;

    int n_run = 0, n_fail = 0;

    cmd_proto_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .din_lo_wr(din_lo_wr), .din_hi_wr(din_hi_wr), .din_word(din_word),
        .resp_ready(resp_ready), .dout_rd_done(dout_rd_done),
        .app_status(app_status), .status(status), .exec_valid(exec_valid),
        .exec_code(exec_code), .exec_app(exec_app), .exec_param(exec_param),
        .err_pulse(err_pulse), .in_size(in_size), .out_size(out_size),
        .fs_set(fs_set)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock of stimulus driven at a falling edge; outputs read after
    task automatic step(input logic c, input logic [15:0] cw, input logic lo,
                        input logic hi, input logic [15:0] dw,
                        input logic rr, input logic rd);
        @(negedge clk);
        cmd_wr = c; cmd_word = cw; din_lo_wr = lo; din_hi_wr = hi;
        din_word = dw; resp_ready = rr; dout_rd_done = rd;
        @(negedge clk);
        cmd_wr = 0; din_lo_wr = 0; din_hi_wr = 0; resp_ready = 0;
        dout_rd_done = 0;
    endtask

    task automatic send_cmd(input logic [15:0] w); step(1, w, 0, 0, 0, 0, 0); endtask
    task automatic send_lo(input logic [15:0] w);  step(0, 0, 1, 0, w, 0, 0); endtask
    task automatic send_hi(input logic [15:0] w);  step(0, 0, 0, 1, w, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status[4:0] == 0, "R1", {27'd0, status[4:0]}, 0);
        chk(!exec_valid && !err_pulse, "R1", {exec_valid, err_pulse}, 0);
        chk(in_size == 0 && out_size == 0 && fs_set == 0, "R1", in_size | out_size | fs_set, 0);
        // R11 free bits follow the input
        chk(status[15:5] == 11'h2A5, "R11", status[15:5], 11'h2A5);
        app_status = 11'h15A;
        #1 chk(status[15:5] == 11'h15A, "R11", status[15:5], 11'h15A);

        // Sweep: all default codes with all flag combinations
        for (int code = 0; code < 16; code++) begin
            for (int lb = 0; lb < 4; lb++) begin
                logic [7:0]  app;
                logic [15:0] lo, hi, w;
                logic [31:0] ep;
                logic        known;
                app   = 8'(code * 16 + lb + 8'h30);
                lo    = 16'(16'hA000 + code * 4 + lb);
                hi    = 16'(16'h5000 + code * 4 + lb);
                w     = {app, 4'(code), 2'b00, 2'(lb)};
                known = (code <= 3) || (code >= 12);
                send_cmd(w);
                if (!known) begin
                    chk(err_pulse && !exec_valid, "R3", {err_pulse, exec_valid}, 2'b10);
                    chk(status[3:0] == 0, "R3", status[3:0], 0);
                    continue;
                end
                chk(!err_pulse, "R2", err_pulse, 0);
                if (lb[0] == 0) begin
                    ep = 0;
                    chk(exec_valid && exec_param == 0, "R2", exec_param, 0);
                end else begin
                    chk(!exec_valid && status[3] && status[1] == lb[1] && status[0] == !lb[1],
                        lb[1] ? "R5" : "R4", status[3:0], {1'b1, 1'b0, lb[1], !lb[1]});
                    send_lo(lo);
                    if (lb[1] == 0) begin
                        ep = {16'd0, lo};
                        chk(exec_valid && exec_param == ep, "R4", exec_param, ep);
                        chk(status[3] == 0 && status[1:0] == 0, "R4", status[3:0], 0);
                    end else begin
                        chk(!exec_valid && status[1] && status[3], "R5", status[3:0], 4'b1010);
                        send_hi(hi);
                        ep = {hi, lo};
                        chk(exec_valid && exec_param == ep, "R5", exec_param, ep);
                        chk(status[3] == 0 && status[1] == 0, "R5", status[3:0], 0);
                    end
                end
                chk(exec_code == 4'(code), "R2", exec_code, code);
                chk(exec_app == app, "R2", exec_app, app);
                if (code == 2) begin
                    chk(in_size == ep, "R8", in_size, ep);
                    chk(status[2] == (ep != 0), "R9", status[2], ep != 0);
                    send_cmd(16'h00D0);
                    chk(status[2] == 0, "R9", status[2], 0);
                end
                if (code == 3)  chk(out_size == ep, "R8", out_size, ep);
                if (code == 14) chk(fs_set == ep, "R8", fs_set, ep);
            end
        end

        // R9 countdown with only low writes outside a parameter counted
        send_cmd(16'h0021);
        send_lo(16'd3);
        chk(status[2] == 1, "R9", status[2], 1);
        send_lo(16'h1111);
        send_hi(16'h2222);
        send_lo(16'h3333);
        chk(status[2] == 1, "R9", status[2], 1);
        send_cmd(16'h0031);       // narrow parameter: this low write is not data
        send_lo(16'h0044);
        chk(status[2] == 1 && out_size == 32'h44, "R9", status[2], 1);
        send_lo(16'h5555);
        chk(status[2] == 0, "R9", status[2], 0);

        // R6 misordered writes are ignored
        send_cmd(16'h12E3);
        send_hi(16'hDEAD);
        chk(!exec_valid && status[1], "R6", status[3:0], 4'b1010);
        send_lo(16'h0BEE);
        send_lo(16'hFFFF);
        chk(!exec_valid && status[1], "R6", status[3:0], 4'b1010);
        send_hi(16'h0001);
        chk(exec_valid && exec_param == 32'h0001_0BEE, "R6", exec_param, 32'h0001_0BEE);
        chk(fs_set == 32'h0001_0BEE, "R8", fs_set, 32'h0001_0BEE);

        // R7 abort by a new command, then a stray high write
        send_cmd(16'h0033);
        send_lo(16'h1234);
        send_cmd(16'h7700);
        chk(exec_valid && exec_code == 0 && exec_app == 8'h77, "R7", exec_code, 0);
        chk(status[3:0] == 0, "R7", status[3:0], 0);
        send_hi(16'h9999);
        chk(!exec_valid && out_size == 32'h44, "R7", out_size, 32'h44);
        // R7 command write beats a same-cycle low write
        send_cmd(16'h00F1);
        step(1, 16'h00F0, 1, 0, 16'hAAAA, 0, 0);
        chk(exec_valid && exec_code == 4'hF && exec_param == 0, "R7", exec_param, 0);
        // R3 unknown code drops a pending parameter
        send_cmd(16'h0031);
        send_cmd(16'h0050);
        chk(err_pulse && status[3] == 0, "R3", status[3:0], 0);
        send_lo(16'h0077);
        chk(!exec_valid && out_size == 32'h44, "R3", out_size, 32'h44);

        // R10 data-ready flag
        step(0, 0, 0, 0, 0, 1, 0);
        chk(status[4] == 1, "R10", status[4], 1);
        step(0, 0, 0, 0, 0, 0, 1);
        chk(status[4] == 0, "R10", status[4], 0);
        step(0, 0, 0, 0, 0, 1, 1);
        chk(status[4] == 1, "R10", status[4], 1);
        send_cmd(16'h00C0);
        chk(status[4] == 0 && exec_valid, "R10", status[4], 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule